// File: doc/BRIEF.md
# Control IN Endpoint Command Register

This block holds the application-visible command and state word for a USB device control IN endpoint and picks the handshake that endpoint returns to the host. The application writes a 32-bit word to start the endpoint, to request that it stop, to raise or drop its NAK state, to force a STALL, and to choose the transmit FIFO. The device core reports three events as single-cycle pulses: a SETUP packet received, a transfer finished, and an acknowledged disable. It also supplies two global NAK levels.

The endpoint's own bits are cleared by these core events, and each clear lands before the matching interrupt pulse. The handshake output names STALL, NAK or data, with STALL above every NAK source. Moving packets, FIFO storage and bus signalling are handled elsewhere.

Top module: `ctl_ep_reg`

## Requirements
- R1: After reset, rd_data reads 0x00000000, both interrupt outputs are low, and hs_sel reads NAK.
- R2: Writing 1 to bit 31 sets the enable state, which reads back at bit 31. A transfer-complete or disable-acknowledge pulse clears it at the same edge, and the clear wins over a set written in that cycle.
- R3: Writing 1 to bit 30 sets the disable state, which reads back at bit 30, only if enable was already set before that write. Otherwise the write has no effect. A disable-acknowledge pulse clears it.
- R4: Writing 1 to bit 27 sets the NAK state. Writing 1 to bit 26 clears it, and bit 27 wins when both are written. Bits 27 and 26 always read 0. The NAK state reads back at bit 17.
- R5: A SETUP pulse sets the NAK state and clears STALL at that edge. This overrides a STALL write and a NAK-clear write made in the same cycle.
- R6: Writing 1 to bit 21 sets STALL, which reads back at bit 21. Writing 0 to bit 21 leaves STALL unchanged.
- R7: hs_sel encodes 2'b10 for STALL, 2'b01 for NAK and 2'b00 for data. STALL is chosen whenever it is set. Otherwise NAK is chosen when the NAK state, global IN NAK or global OUT NAK is set, or when enable is clear. Otherwise data is chosen.
- R8: A transfer-complete pulse sampled at edge k gives a one-cycle xfer_irq pulse after edge k+1. Enable is already clear in the cycle before that pulse.
- R9: A disable-acknowledge pulse sampled at edge k gives a one-cycle dis_irq pulse after edge k+1. Enable and disable are both already clear in the cycle before that pulse.
- R10: Bits 25:22 hold the FIFO number, which any write replaces. Bits 29:28, 20 and 19:18 (endpoint type, control) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Application write strobe |
| wr_data | input | 32 | Application write word |
| rd_data | output | 32 | Register read value |
| setup_rcvd | input | 1 | SETUP packet received pulse |
| xfer_done | input | 1 | Transfer complete pulse |
| dis_ack | input | 1 | Disable acknowledged pulse |
| gin_nak | input | 1 | Global IN NAK level |
| gout_nak | input | 1 | Global OUT NAK level |
| hs_sel | output | 2 | Handshake choice: 10 STALL, 01 NAK, 00 data |
| xfer_irq | output | 1 | Transfer-completed interrupt pulse |
| dis_irq | output | 1 | Endpoint-disabled interrupt pulse |

## Verification
The assertions assume that each core event is a single-cycle pulse. They also assume the two interrupts always follow their events by exactly two edges, whatever the application writes in the meantime. The stimulus raises each event pulse for one cycle only and changes the global NAK levels only between writes. With these inputs, every cycle stays within what the properties assume.

// File: rtl/ctl_ep_reg.sv
module ctl_ep_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        setup_rcvd,
  input  logic        xfer_done,
  input  logic        dis_ack,
  input  logic        gin_nak,
  input  logic        gout_nak,
  output logic [1:0]  hs_sel,
  output logic        xfer_irq,
  output logic        dis_irq
);
  localparam logic [1:0] HS_DATA  = 2'b00;
  localparam logic [1:0] HS_NAK   = 2'b01;
  localparam logic [1:0] HS_STALL = 2'b10;

  logic       ena, dis, nak, stall, xfer_pend, dis_pend;
  logic [3:0] fifo_num;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena <= 1'b0;
      dis <= 1'b0;
      nak <= 1'b0;
      stall <= 1'b0;
      fifo_num <= '0;
      xfer_pend <= 1'b0;
      dis_pend <= 1'b0;
      xfer_irq <= 1'b0;
      dis_irq <= 1'b0;
    end else begin
      if (wr_en && wr_data[31]) ena <= 1'b1;
      if (wr_en && wr_data[30] && ena) dis <= 1'b1;
      if (xfer_done || dis_ack) ena <= 1'b0;
      if (dis_ack) dis <= 1'b0;
      if (wr_en && wr_data[26]) nak <= 1'b0;
      if (wr_en && wr_data[27]) nak <= 1'b1;
      if (setup_rcvd) nak <= 1'b1;
      if (wr_en && wr_data[21]) stall <= 1'b1;
      if (setup_rcvd) stall <= 1'b0;
      if (wr_en) fifo_num <= wr_data[25:22];
      xfer_pend <= xfer_done;
      dis_pend <= dis_ack;
      xfer_irq <= xfer_pend;
      dis_irq <= dis_pend;
    end
  end

  assign rd_data = {ena, dis, 4'b0000, fifo_num, stall, 3'b000, nak, 17'd0};

  assign hs_sel = stall ? HS_STALL :
                  (nak || gin_nak || gout_nak || !ena) ? HS_NAK : HS_DATA;
endmodule

module ctl_ep_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        setup_rcvd,
  input logic [1:0]  hs_sel,
  input logic        xfer_irq,
  input logic        dis_irq
);
  // R5
  setup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rcvd |=> (!rd_data[21] && rd_data[17]));
  // R7
  stall_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[21] |-> hs_sel == 2'b10);
  // R8
  xfer_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_irq |-> !$past(rd_data[31]));
  // R9
  dis_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_irq |-> (!$past(rd_data[31]) && !$past(rd_data[30])));
  // R3
  dis_needs_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[30]) |-> $past(rd_data[31]));
  // R10
  zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[29:26] == 4'd0 && rd_data[20:18] == 3'd0));
endmodule

bind ctl_ep_reg ctl_ep_reg_chk chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .setup_rcvd(setup_rcvd),
  .hs_sel(hs_sel), .xfer_irq(xfer_irq), .dis_irq(dis_irq));

// File: tb/ctl_ep_reg_test.sv
module ctl_ep_reg_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic setup_rcvd = 1'b0, xfer_done = 1'b0, dis_ack = 1'b0, gin_nak = 1'b0, gout_nak = 1'b0;
  logic [31:0] rd_data;
  logic [1:0] hs_sel;
  logic xfer_irq, dis_irq;

  int checks = 0, fails = 0;
  logic m_ena, m_dis, m_nak, m_stall, m_xp, m_dp, m_xi, m_di;
  logic [3:0] m_fifo;

  ctl_ep_reg uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .setup_rcvd(setup_rcvd), .xfer_done(xfer_done), .dis_ack(dis_ack), .gin_nak(gin_nak),
    .gout_nak(gout_nak), .hs_sel(hs_sel), .xfer_irq(xfer_irq), .dis_irq(dis_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {m_ena, m_dis, 4'b0000, m_fifo, m_stall, 3'b000, m_nak, 17'd0};
  endfunction

  function automatic logic [1:0] exp_hs();
    if (m_stall) return 2'b10;
    if (m_nak || gin_nak || gout_nak || !m_ena) return 2'b01;
    return 2'b00;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    {m_ena, m_dis, m_nak, m_stall, m_xp, m_dp, m_xi, m_di} = '0;
    m_fifo = '0;
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic s, input logic x, input logic a);
    @(negedge clk);
    wr_en = w; wr_data = d; setup_rcvd = s; xfer_done = x; dis_ack = a;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0; setup_rcvd = 1'b0; xfer_done = 1'b0; dis_ack = 1'b0;
    if (w && d[30] && m_ena) m_dis = 1'b1;
    if (w && d[31]) m_ena = 1'b1;
    if (x || a) m_ena = 1'b0;
    if (a) m_dis = 1'b0;
    if (w && d[26]) m_nak = 1'b0;
    if (w && d[27]) m_nak = 1'b1;
    if (s) m_nak = 1'b1;
    if (w && d[21]) m_stall = 1'b1;
    if (s) m_stall = 1'b0;
    if (w) m_fifo = d[25:22];
    m_xi = m_xp; m_di = m_dp; m_xp = x; m_dp = a;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " word"}, rd_data, exp_word());
    chk({tag, " hs R7"}, {30'd0, hs_sel}, {30'd0, exp_hs()});
    chk({tag, " irq R8 R9"}, {30'd0, xfer_irq, dis_irq}, {30'd0, m_xi, m_di});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset hs", {30'd0, hs_sel}, 32'd1);
    chk("R1 reset irq", {30'd0, xfer_irq, dis_irq}, 32'd0);

    // R2 R3 R4 R6 R10: sweep command bit patterns from four start states
    for (int st = 0; st < 4; st++) begin
      for (int p = 0; p < 32; p++) begin
        logic [31:0] d;
        d = {p[4], p[3], 2'b11, p[2], p[1], p[3:0], p[0], 1'b1, 2'b11, 18'h3ffff};
        do_reset();
        if (st[0]) step(1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
        if (st[1]) step(1'b1, 32'h0020_0000, 1'b0, 1'b0, 1'b0);
        step(1'b1, d, 1'b0, 1'b0, 1'b0);
        check_all("R2 R3 R4 R6 R10 sweep");
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        check_all("R6 zero write");
      end
    end

    // R7: global NAK levels with stall off and on
    for (int sv = 0; sv < 2; sv++) begin
      for (int g = 0; g < 4; g++) begin
        do_reset();
        step(1'b1, sv[0] ? 32'h8020_0000 : 32'h8000_0000, 1'b0, 1'b0, 1'b0);
        @(negedge clk); gin_nak = g[0]; gout_nak = g[1];
        #1 check_all("R7 global nak");
        @(negedge clk); gin_nak = 1'b0; gout_nak = 1'b0;
      end
    end

    // R5: SETUP beats stall set and nak clear
    do_reset();
    step(1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0420_0000, 1'b1, 1'b0, 1'b0);
    check_all("R5 setup priority");
    chk("R5 stall cleared", {31'd0, rd_data[21]}, 32'd0);
    step(1'b1, 32'h0420_0000, 1'b0, 1'b0, 1'b0);
    check_all("R5 stall after setup");

    // R8: transfer complete, clear wins over same-cycle enable write (R2)
    do_reset();
    step(1'b1, 32'h8400_0000, 1'b0, 1'b0, 1'b0);
    chk("R2 enabled data hs", {30'd0, hs_sel}, 32'd0);
    step(1'b1, 32'h8000_0000, 1'b0, 1'b1, 1'b0);
    check_all("R2 R8 edge k");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check_all("R8 edge k+1");
    chk("R8 pulse", {31'd0, xfer_irq}, 32'd1);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check_all("R8 pulse end");

    // R9: disable then acknowledge
    do_reset();
    step(1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0);
    check_all("R3 disable ignored");
    step(1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0);
    check_all("R3 disable taken");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
    check_all("R9 edge k");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check_all("R9 edge k+1");
    chk("R9 pulse", {31'd0, dis_irq}, 32'd1);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check_all("R9 pulse end");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule